// File: doc/BRIEF.md
# Serial Peripheral Slave with Buffered Transmit

This block is the slave end of a four-wire synchronous serial link. It runs on the system bus clock. It swaps one byte with an external master in each transfer: one bit leaves on the output data line on every serial clock cycle while one bit arrives on the input data line. The register side has a control write (enable, clock polarity, clock phase), a transmit byte write, a received byte read strobe, and the receive status flags. The serial clock, select and input data lines are synchronised into the bus domain and their edges are found there, so the serial clock must run well below the bus clock.

A transmit byte written by software goes into a holding buffer. It moves into the transmit position only when a transfer starts. If no new byte is waiting when a transfer starts, the byte sent last time is sent again. The state machine has three states. `ST_OFF` is left on *enable*. `ST_IDLE` waits for a *start* and goes back to `ST_OFF` on *disable*. `ST_SHIFT` returns to `ST_IDLE` on *finish* (last bit sampled) or *abort* (select released), and to `ST_OFF` on *disable*. The start event depends on clock phase. With phase 0 it is the falling edge of select. With phase 1 it is the first leading serial clock edge while the slave is selected.

Top module: `spi_slave_buf`

## Requirements
- R1: After reset the block is disabled with polarity 0 and phase 0. The receive flags are clear, the received byte is 0x00, and the output data line is 0 and not driven.
- R2: In all four polarity/phase modes a transfer exchanges one byte each way, most significant bit first. For phase 0 the slave samples on the leading serial clock edge (the first edge away from the idle level). For phase 1 it samples on the trailing edge. It changes its output on the other edge.
- R3: With phase 0 the transfer starts when select falls, and the first bit is on the output line before the first clock edge. With phase 1 the transfer starts at the first leading edge, so a byte written after select falls but before that edge is still sent.
- R4: A transmit byte written during a transfer does not disturb it. It is sent in the next transfer.
- R5: A transmit byte written after a transfer has started is too late for that transfer, and the previous transmit byte is sent again. The late byte goes out in the following transfer.
- R6: While select is high the output data line is not driven (enable low, data 0), and serial clock edges neither shift nor complete a byte.
- R7: A control write always updates enable. It updates polarity and phase only if enable was clear before the write.
- R8: When the last bit is sampled, the received byte is stored and the receive-full flag is set. A read strobe clears the receive-full and overrun flags.
- R9: If a byte completes while receive-full is set and no read strobe is present, the overrun flag is set and the stored byte is kept.
- R10: A read strobe in the same bus cycle as a byte completion counts as coming first: the new byte is stored, receive-full stays set and overrun is clear.
- R11: With phase 1, back-to-back transfers with select held low each start at their own first leading edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control write strobe |
| ctrl_en | input | 1 | Enable value for control write |
| ctrl_cpol | input | 1 | Clock polarity value (idle level of serial clock) |
| ctrl_cpha | input | 1 | Clock phase value |
| tx_wr | input | 1 | Transmit byte write strobe |
| tx_data | input | 8 | Transmit byte |
| rx_rd | input | 1 | Received byte read strobe |
| rx_data | output | 8 | Received byte |
| rx_full | output | 1 | Receive-full flag |
| rx_ovr | output | 1 | Overrun flag |
| cfg_en | output | 1 | Current enable |
| cfg_cpol | output | 1 | Current polarity |
| cfg_cpha | output | 1 | Current phase |
| sck | input | 1 | Serial clock from master |
| ss_n | input | 1 | Slave select, active low |
| mosi | input | 1 | Serial data in |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for serial data out |

## Verification
The byte-completion event and a software read strobe can fall in the same bus cycle, and so can a completion and the overrun decision. The bench provokes the collision by pulsing the read strobe exactly two bus cycles after it moves the final sampling edge. That cycle is the one in which the synchronised edge reaches the receive register. The bench then checks that the value captured before the strobe is the old byte, and that afterwards the new byte is stored with receive-full set and overrun clear. Separate runs without a read show the overrun path keeping the old byte.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;
    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_IDLE  = 2'd1,
        ST_SHIFT = 2'd2
    } slv_state_t;
endpackage

// File: rtl/spi_slv_sync.sv
module spi_slv_sync #(
    parameter int WIDTH = 3,
    parameter int STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_slv_engine.sv
module spi_slv_engine
    import spi_slv_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              sck_s,
    input  logic              ss_s,
    input  logic              mosi_s,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    output logic              miso,
    output logic              miso_oe,
    output logic              done,
    output logic [DATA_W-1:0] rx_byte
);
    localparam int OIDX_W = $clog2(DATA_W);
    localparam int CNT_W  = $clog2(DATA_W + 1);

    slv_state_t state, nstate;

    logic              sck_d, ss_d;
    logic [DATA_W-1:0] tx_buf, tx_cur;
    logic              tx_pend;
    logic [OIDX_W-1:0] oidx, bit_sel;
    logic [CNT_W-1:0]  icnt;
    logic [DATA_W-2:0] rx_sh;

    logic sck_chg, lead, trail, ss_fall, start, sample, advance, last;

    assign sck_chg = sck_s ^ sck_d;
    assign lead    = sck_chg && (sck_d == cpol);
    assign trail   = sck_chg && (sck_d != cpol);
    assign ss_fall = ss_d && !ss_s;
    assign start   = (state == ST_IDLE) && !ss_s && (cpha ? lead : ss_fall);
    assign sample  = (state == ST_SHIFT) && !ss_s && (cpha ? trail : lead);
    assign advance = (state == ST_SHIFT) && !ss_s && (cpha ? lead : trail);
    assign last    = sample && (icnt == CNT_W'(DATA_W - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nstate;
    end

    // transitions: enable, start, finish, abort, disable
    always_comb begin
        nstate = state;
        unique case (state)
            ST_OFF:   if (en) nstate = ST_IDLE;
            ST_IDLE:  if (!en) nstate = ST_OFF;
                      else if (start) nstate = ST_SHIFT;
            ST_SHIFT: if (!en) nstate = ST_OFF;
                      else if (ss_s || last) nstate = ST_IDLE;
            default:  nstate = ST_OFF;
        endcase
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d   <= 1'b0;
            ss_d    <= 1'b1;
            tx_buf  <= '0;
            tx_cur  <= '0;
            tx_pend <= 1'b0;
            oidx    <= '0;
            icnt    <= '0;
            rx_sh   <= '0;
        end else begin
            sck_d <= sck_s;
            ss_d  <= ss_s;
            if (start) begin
                if (tx_pend) tx_cur <= tx_buf;
                oidx <= '0;
                icnt <= '0;
            end
            if (tx_wr) begin
                tx_buf  <= tx_data;
                tx_pend <= 1'b1;
            end else if (start) begin
                tx_pend <= 1'b0;
            end
            if (advance) oidx <= oidx + 1'b1;
            if (sample) begin
                rx_sh <= {rx_sh[DATA_W-3:0], mosi_s};
                icnt  <= icnt + 1'b1;
            end
        end
    end

    // outputs
    assign bit_sel = OIDX_W'(DATA_W - 1) - oidx;
    always_comb begin
        miso_oe = (state != ST_OFF) && !ss_s;
        miso    = miso_oe & tx_cur[bit_sel];
        done    = last;
        rx_byte = {rx_sh, mosi_s};
    end

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        icnt <= CNT_W'(DATA_W));
    p_pend_consumed_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && tx_pend && !tx_wr) |=> !tx_pend);
endmodule

// File: rtl/spi_slv_regs.sv
module spi_slv_regs #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              wr_en,
    input  logic              wr_cpol,
    input  logic              wr_cpha,
    input  logic              rx_rd,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_byte,
    output logic              cfg_en,
    output logic              cfg_cpol,
    output logic              cfg_cpha,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_en   <= 1'b0;
            cfg_cpol <= 1'b0;
            cfg_cpha <= 1'b0;
        end else if (ctrl_wr) begin
            cfg_en <= wr_en;
            if (!cfg_en) begin
                cfg_cpol <= wr_cpol;
                cfg_cpha <= wr_cpha;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
        end else if (done) begin
            if (rx_full && !rx_rd) begin
                rx_ovr <= 1'b1;
            end else begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
                rx_ovr  <= 1'b0;
            end
        end else if (rx_rd) begin
            rx_full <= 1'b0;
            rx_ovr  <= 1'b0;
        end
    end

    p_full_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> rx_full);
    p_ovr_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !rx_rd) |=> (rx_ovr && $stable(rx_data)));
    p_read_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_rd) |=> (rx_full && !rx_ovr));
    p_mode_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_en) |-> ($stable(cfg_cpol) && $stable(cfg_cpha)));
endmodule

// File: rtl/spi_slave_buf.sv
module spi_slave_buf #(
    parameter int DATA_W = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              ctrl_cpol,
    input  logic              ctrl_cpha,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_full,
    output logic              rx_ovr,
    output logic              cfg_en,
    output logic              cfg_cpol,
    output logic              cfg_cpha,
    input  logic              sck,
    input  logic              ss_n,
    input  logic              mosi,
    output logic              miso,
    output logic              miso_oe
);
    logic [2:0]        sync_q;
    logic              done;
    logic [DATA_W-1:0] rx_byte;

    spi_slv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst_n(rst_n), .d({ss_n, sck, mosi}), .q(sync_q)
    );

    spi_slv_engine #(.DATA_W(DATA_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .en(cfg_en), .cpol(cfg_cpol), .cpha(cfg_cpha),
        .sck_s(sync_q[1]), .ss_s(sync_q[2]), .mosi_s(sync_q[0]),
        .tx_wr(tx_wr), .tx_data(tx_data),
        .miso(miso), .miso_oe(miso_oe), .done(done), .rx_byte(rx_byte)
    );

    spi_slv_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wr_en(ctrl_en),
        .wr_cpol(ctrl_cpol), .wr_cpha(ctrl_cpha), .rx_rd(rx_rd),
        .done(done), .rx_byte(rx_byte),
        .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .rx_data(rx_data), .rx_full(rx_full), .rx_ovr(rx_ovr)
    );
endmodule

// File: tb/sim_spi_slave_buf.sv
module sim_spi_slave_buf;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctrl_wr = 0, ctrl_en = 0, ctrl_cpol = 0, ctrl_cpha = 0;
    logic tx_wr = 0;
    logic [7:0] tx_data = '0;
    logic rx_rd = 0;
    logic [7:0] rx_data;
    logic rx_full, rx_ovr, cfg_en, cfg_cpol, cfg_cpha;
    logic sck = 0, ss_n = 1, mosi = 0;
    logic miso, miso_oe;

    always #2 clk = ~clk;

    spi_slave_buf u0 (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_en(ctrl_en),
        .ctrl_cpol(ctrl_cpol), .ctrl_cpha(ctrl_cpha), .tx_wr(tx_wr),
        .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .rx_full(rx_full),
        .rx_ovr(rx_ovr), .cfg_en(cfg_en), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .sck(sck), .ss_n(ss_n), .mosi(mosi), .miso(miso), .miso_oe(miso_oe)
    );

    int checks = 0;
    int fails = 0;
    bit done_flag = 0;

    // behavioural model
    bit mcpol = 0, mcpha = 0;
    logic [7:0] m_cur = 8'h00, m_buf = 8'h00;
    bit m_pend = 0;
    logic [7:0] m_data = 8'h00;
    bit m_full = 0, m_ovr = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // per-clock monitor: deselected slave must not drive
    int ss_hi = 0;
    always @(negedge clk) begin
        if (rst_n && !done_flag) begin
            if (ss_n) ss_hi++; else ss_hi = 0;
            if (ss_hi >= 4)
                chk(!miso_oe && !miso, "R6", "deselected drive", {miso_oe, miso}, 0);
        end
    end

    task automatic ctrl(input bit en, input bit cp, input bit ph);
        @(negedge clk);
        ctrl_wr = 1; ctrl_en = en; ctrl_cpol = cp; ctrl_cpha = ph;
        @(negedge clk);
        ctrl_wr = 0;
    endtask

    task automatic set_mode(input bit cp, input bit ph);
        ctrl(0, cp, ph);
        sck = cp;
        mcpol = cp; mcpha = ph;
        repeat (4) @(negedge clk);
        ctrl(1, cp, ph);
        chk(cfg_cpol == cp && cfg_cpha == ph && cfg_en, "R2", "mode set",
            {cfg_en, cfg_cpol, cfg_cpha}, {1'b1, cp, ph});
    endtask

    task automatic txw(input logic [7:0] b);
        @(negedge clk);
        tx_wr = 1; tx_data = b;
        @(negedge clk);
        tx_wr = 0;
        m_buf = b; m_pend = 1;
    endtask

    task automatic m_start();
        if (m_pend) begin m_cur = m_buf; m_pend = 0; end
    endtask

    task automatic rd_check(input string req);
        @(negedge clk);
        chk(rx_full == m_full, req, "rx_full", rx_full, m_full);
        chk(rx_ovr == m_ovr, req, "rx_ovr", rx_ovr, m_ovr);
        chk(rx_data == m_data, req, "rx_data", rx_data, m_data);
        rx_rd = 1;
        @(negedge clk);
        rx_rd = 0;
        m_full = 0; m_ovr = 0;
        @(negedge clk);
        chk(!rx_full && !rx_ovr, "R8", "flags after read", {rx_full, rx_ovr}, 0);
    endtask

    // master transfer; pre_wr>=0 writes that byte after select falls (phase 1 only)
    task automatic xfer(input logic [7:0] mo, input bit keep_ss, input bit rd_end,
                        input int pre_wr, input string req);
        logic [7:0] mi;
        logic [7:0] old_cap;
        logic [7:0] exp_tx;
        mi = '0; old_cap = '0;
        if (!mcpha) m_start();
        @(negedge clk);
        ss_n = 0;
        repeat (H) @(negedge clk);
        if (pre_wr >= 0) begin
            txw(pre_wr[7:0]);
            repeat (2) @(negedge clk);
        end
        if (mcpha) m_start();
        exp_tx = m_cur;
        for (int i = 0; i < 8; i++) begin
            if (!mcpha) begin
                mosi = mo[7-i];
                if (i == 0)
                    chk(miso == exp_tx[7], "R3", "first bit before edge", miso, exp_tx[7]);
                repeat (H) @(negedge clk);
                mi[7-i] = miso;
                sck = ~mcpol;
                if (i == 7 && rd_end) begin
                    repeat (2) @(negedge clk);
                    old_cap = rx_data; rx_rd = 1;
                    @(negedge clk);
                    rx_rd = 0;
                    repeat (H - 3) @(negedge clk);
                end else begin
                    repeat (H) @(negedge clk);
                end
                sck = mcpol;
            end else begin
                sck = ~mcpol;
                mosi = mo[7-i];
                repeat (H) @(negedge clk);
                mi[7-i] = miso;
                sck = mcpol;
                if (i == 7 && rd_end) begin
                    repeat (2) @(negedge clk);
                    old_cap = rx_data; rx_rd = 1;
                    @(negedge clk);
                    rx_rd = 0;
                    repeat (H - 3) @(negedge clk);
                end else begin
                    repeat (H) @(negedge clk);
                end
            end
        end
        repeat (H) @(negedge clk);
        if (!keep_ss) begin
            ss_n = 1;
            repeat (H) @(negedge clk);
        end
        chk(mi == exp_tx, req, "byte seen by master", mi, exp_tx);
        if (rd_end) begin
            chk(old_cap == m_data, "R10", "old byte at read", old_cap, m_data);
            m_data = mo; m_full = 1; m_ovr = 0;
        end else if (m_full) begin
            m_ovr = 1;
        end else begin
            m_data = mo; m_full = 1;
        end
        chk(rx_full == m_full && rx_ovr == m_ovr, req, "flags after transfer",
            {rx_full, rx_ovr}, {m_full, m_ovr});
        chk(rx_data == m_data, req, "stored byte", rx_data, m_data);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!rx_full && !rx_ovr && rx_data == 8'h00, "R1", "rx after reset",
            {rx_full, rx_ovr, rx_data}, 0);
        chk(!cfg_en && !cfg_cpol && !cfg_cpha, "R1", "cfg after reset",
            {cfg_en, cfg_cpol, cfg_cpha}, 0);
        chk(!miso_oe && !miso, "R1", "miso after reset", {miso_oe, miso}, 0);

        // R2 all four modes
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            txw(8'hA5 ^ 8'(m * 8'h33));
            xfer(8'h3C + 8'(m), 0, 0, -1, "R2");
            rd_check("R8");
        end

        // R7 mode bits locked while enabled
        set_mode(0, 0);
        ctrl(1, 1, 1);
        chk(!cfg_cpol && !cfg_cpha && cfg_en, "R7", "mode ignored when enabled",
            {cfg_en, cfg_cpol, cfg_cpha}, 3'b100);
        ctrl(0, 1, 1);
        chk(!cfg_en && !cfg_cpol && !cfg_cpha, "R7", "disable write",
            {cfg_en, cfg_cpol, cfg_cpha}, 3'b000);

        // R4 mid-transfer write, phase 1
        set_mode(0, 1);
        txw(8'h11);
        fork
            xfer(8'h96, 0, 0, -1, "R4");
            begin repeat (60) @(negedge clk); txw(8'h22); end
        join
        rd_check("R4");
        xfer(8'h69, 0, 0, -1, "R4");
        rd_check("R4");

        // R5 late write, phase 0
        set_mode(0, 0);
        fork
            xfer(8'h5A, 0, 0, -1, "R5");
            begin repeat (6) @(negedge clk); txw(8'h77); end
        join
        rd_check("R5");
        xfer(8'hC1, 0, 0, -1, "R5");
        rd_check("R5");

        // R9 overrun
        txw(8'h01);
        xfer(8'hE0, 0, 0, -1, "R9");
        xfer(8'h0E, 0, 0, -1, "R9");
        rd_check("R9");

        // R10 read colliding with completion
        xfer(8'h44, 0, 0, -1, "R10");
        xfer(8'h88, 0, 1, -1, "R10");
        rd_check("R10");

        // R6 clock activity while deselected
        set_mode(1, 1);
        for (int k = 0; k < 16; k++) begin
            sck = ~sck; mosi = k[0];
            repeat (H) @(negedge clk);
        end
        chk(!rx_full && !rx_ovr, "R6", "no byte while deselected", {rx_full, rx_ovr}, 0);
        txw(8'hB7);
        xfer(8'h7B, 0, 0, -1, "R6");
        rd_check("R6");

        // R3 phase 1: write after select but before first edge is used
        xfer(8'h12, 0, 0, 8'hD4, "R3");
        rd_check("R3");

        // R11 back-to-back phase 1 with select held low
        set_mode(0, 1);
        txw(8'hC3);
        xfer(8'hAB, 1, 0, -1, "R11");
        rd_check("R11");
        txw(8'h3C);
        xfer(8'hCD, 0, 0, -1, "R11");
        rd_check("R11");

        done_flag = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule